// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block is the host-side engine that writes one page into a byte-wide NAND flash device. A client raises `start` for one clock with a 32-bit address (four address bytes), a byte count and a completion mode. It then supplies the payload through a valid/ready byte stream. The sequencer drives chip enable, the command and address latch enables, and the write and read strobes on an 8-bit bus. It issues the load command, the four address bytes, the payload and the confirm command. It then waits for the device to finish and reads the status register to decide pass or fail.

Two completion modes exist. In ready/busy mode the sequencer waits until the busy pin goes high again and then reads status once. In polling mode it issues the status command straight after the confirm and keeps reading status until the ready bit is set. In both modes a wait counter bounded by `tmo_lim` aborts the operation if the device stays busy too long. A request with an illegal byte count is refused at once, and the bus is left untouched.

States: `S_IDLE` (waiting for a request), `S_CMD_LOAD` (80h), `S_ADDR` (four address bytes), `S_DATA` (payload), `S_CMD_CONF` (10h), `S_WAIT_RB` (busy-pin wait, ready/busy mode only), `S_CMD_STAT` (70h) and `S_READ_STAT` (status read). Transitions:
- idle→load on a legal start.
- load→addr and conf→stat or conf→wait_rb on the end of a strobe cycle.
- addr→data after the fourth address byte.
- data→conf after the last payload byte.
- wait_rb→stat when the pin is high after a settle delay.
- wait_rb→idle on timeout.
- stat→read at the end of the 70h cycle.
- read→read while the ready bit is clear.
- read→idle when the ready bit is set, or on timeout.

Top module: `nand_pgm_ctrl`

## Requirements
- R1: A legal request produces, in order, command 80h with `nand_cle` high, four address bytes with `nand_ale` high (address bits 7:0 first, then 15:8, 23:16, 31:24), the payload bytes with both latch enables low, and then command 10h with `nand_cle` high. `nand_cle` and `nand_ale` are never high together.
- R2: Byte counts from 1 to 528 are accepted. Exactly that many payload bytes are taken from the stream (a byte transfers on a clock where `din_valid` and `din_ready` are both high) and written in arrival order, including when the stream stalls.
- R3: A start with a byte count of 0 or above 528 yields, on the next clock, `done` with `err_len`=1 and `pass`=0. `nand_ce_n`, `nand_we_n` and `nand_re_n` stay high.
- R4: Every write or read strobe stays low for exactly LOW_CLKS clocks. Between two strobes of one operation it stays high for at least HIGH_CLKS clocks. Write and read strobes are never low together.
- R5: In ready/busy mode (`poll_mode`=0), command 70h is issued only after `nand_rb_n` (1 = ready) is high following the confirm. This is followed by exactly one status read.
- R6: In polling mode (`poll_mode`=1), command 70h is issued once after the confirm. Status reads repeat until status bit 6 (1 = ready) is read as 1.
- R7: `pass` equals the inverse of status bit 0 (0 = success) from the final status read. `done` is high for exactly one clock per operation, and `pass`/`err_len`/`err_tmo` are valid from that clock until the next start.
- R8: If the device is still busy after `tmo_lim` clocks of waiting, the operation ends with `done`, `err_tmo`=1 and `pass`=0, and chip enable is released.
- R9: While `nand_re_n` is low, `nand_ce_n` is low and `nand_io_oe` is low.
- R10: `busy` is high from the clock after a legal start until `done`. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request pulse |
| addr | input | 32 | Four address bytes, bits 7:0 sent first |
| byte_cnt | input | 10 | Payload length in bytes |
| poll_mode | input | 1 | 1 = status polling, 0 = ready/busy pin |
| tmo_lim | input | 20 | Wait limit in clocks |
| din | input | 8 | Payload byte |
| din_valid | input | 1 | Payload byte present |
| din_ready | output | 1 | Sequencer takes the payload byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| pass | output | 1 | Program succeeded |
| err_len | output | 1 | Request refused for byte count |
| err_tmo | output | 1 | Device did not become ready in time |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value driven to the device |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus value read from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The main program path is tried with several patterns:
- Payloads of one byte, the full 528 bytes and mid-sized counts. These separate off-by-one errors in the byte counter from errors in address and data ordering.
- Payloads with a continuous stream and with a stalled stream. These separate the byte hold logic from the strobe timing.
- Both completion modes, with short and long device busy times. Polling runs with long busy times need several status reads, and ready/busy runs must never read status early.
- A device status that reports success and one that reports failure. These show that `pass` follows status bit 0.

Directed cases cover byte counts 0 and 529, a device stuck busy in each mode, and a start raised during an operation.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;
    localparam logic [7:0] OP_LOAD    = 8'h80;
    localparam logic [7:0] OP_CONFIRM = 8'h10;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam int         RDY_BIT    = 6;
    localparam int         FAIL_BIT   = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD_LOAD,
        S_ADDR,
        S_DATA,
        S_CMD_CONF,
        S_WAIT_RB,
        S_CMD_STAT,
        S_READ_STAT
    } pgm_state_t;
endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
    parameter int LOW_CLKS  = 3,
    parameter int HIGH_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic rd,
    output logic we_n,
    output logic re_n,
    output logic sample,
    output logic fin
);
    localparam int SPAN = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
    localparam int CW   = $clog2(SPAN + 1);

    typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} phase_t;

    phase_t        phase_q;
    logic [CW-1:0] cnt_q;
    logic          rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= P_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
        end else begin
            unique case (phase_q)
                P_IDLE: if (req) begin
                    phase_q <= P_LOW;
                    cnt_q   <= '0;
                    rd_q    <= rd;
                end
                P_LOW: if (cnt_q == CW'(LOW_CLKS - 1)) begin
                    phase_q <= P_HIGH;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                P_HIGH: if (cnt_q == CW'(HIGH_CLKS - 1)) begin
                    phase_q <= P_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: phase_q <= P_IDLE;
            endcase
        end
    end

    always_comb begin
        we_n   = !(phase_q == P_LOW && !rd_q);
        re_n   = !(phase_q == P_LOW && rd_q);
        sample = (phase_q == P_LOW)  && (cnt_q == CW'(LOW_CLKS - 1));
        fin    = (phase_q == P_HIGH) && (cnt_q == CW'(HIGH_CLKS - 1));
    end

    // checker: length of each low pulse
    logic [15:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             low_run_q <= '0;
        else if (we_n && re_n)  low_run_q <= '0;
        else                    low_run_q <= low_run_q + 1'b1;
    end

    // R4: low phase is exactly LOW_CLKS clocks
    a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n && re_n) |-> (low_run_q == 16'(LOW_CLKS)));
    // R4: never both strobes low
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    assign expired = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (!expired)      cnt_q <= cnt_q + 1'b1;
    end

    // R8: the count never passes the limit while waiting
    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cnt_q > limit) |-> $stable(cnt_q));
endmodule

// File: rtl/nand_pgm_ctrl.sv
module nand_pgm_ctrl
    import nand_pgm_pkg::*;
#(
    parameter int MAX_BYTES   = 528,
    parameter int LOW_CLKS    = 3,
    parameter int HIGH_CLKS   = 2,
    parameter int SETTLE_CLKS = 4,
    parameter int TMO_W       = 20,
    parameter int LEN_W       = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      addr,
    input  logic [LEN_W-1:0] byte_cnt,
    input  logic             poll_mode,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic [7:0]       din,
    input  logic             din_valid,
    output logic             din_ready,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             err_len,
    output logic             err_tmo,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb_n
);
    localparam int SW = $clog2(SETTLE_CLKS + 1);

    pgm_state_t       state_q, state_d;
    logic [31:0]      addr_q;
    logic [LEN_W-1:0] len_q, idx_q;
    logic             poll_q, hold_q;
    logic [7:0]       byte_q, stat_q;
    logic [SW-1:0]    settle_q;
    logic             done_q, pass_q, elen_q, etmo_q;

    logic req, rd, sample, fin, expired, waiting, bad_len;

    assign bad_len = (byte_cnt == '0) || (byte_cnt > LEN_W'(MAX_BYTES));
    assign waiting = (state_q == S_WAIT_RB) || (state_q == S_CMD_STAT) ||
                     (state_q == S_READ_STAT);

    nand_strobe_gen #(.LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)) strobe_i (
        .clk(clk), .rst_n(rst_n), .req(req), .rd(rd),
        .we_n(nand_we_n), .re_n(nand_re_n), .sample(sample), .fin(fin));

    nand_wait_timer #(.TMO_W(TMO_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(waiting), .limit(tmo_lim),
        .expired(expired));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start && !bad_len) state_d = S_CMD_LOAD;
            S_CMD_LOAD:  if (fin) state_d = S_ADDR;
            S_ADDR:      if (fin && idx_q == LEN_W'(3)) state_d = S_DATA;
            S_DATA:      if (fin && idx_q == len_q - 1'b1) state_d = S_CMD_CONF;
            S_CMD_CONF:  if (fin) state_d = poll_q ? S_CMD_STAT : S_WAIT_RB;
            S_WAIT_RB:   if (expired) state_d = S_IDLE;
                         else if (settle_q == '0 && nand_rb_n) state_d = S_CMD_STAT;
            S_CMD_STAT:  if (fin) state_d = S_READ_STAT;
            S_READ_STAT: if (fin && (stat_q[RDY_BIT] || expired)) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            addr_q   <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            poll_q   <= 1'b0;
            hold_q   <= 1'b0;
            byte_q   <= '0;
            stat_q   <= '0;
            settle_q <= '0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            elen_q   <= 1'b0;
            etmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    done_q <= bad_len;
                    elen_q <= bad_len;
                    etmo_q <= 1'b0;
                    pass_q <= 1'b0;
                    addr_q <= addr;
                    len_q  <= byte_cnt;
                    poll_q <= poll_mode;
                    idx_q  <= '0;
                    hold_q <= 1'b0;
                end
                S_ADDR: if (fin) idx_q <= (idx_q == LEN_W'(3)) ? '0 : idx_q + 1'b1;
                S_DATA: begin
                    if (!hold_q && din_valid) begin
                        hold_q <= 1'b1;
                        byte_q <= din;
                    end
                    if (fin) begin
                        hold_q <= 1'b0;
                        idx_q  <= idx_q + 1'b1;
                    end
                end
                S_CMD_CONF: if (fin) settle_q <= SW'(SETTLE_CLKS);
                S_WAIT_RB: begin
                    if (settle_q != '0) settle_q <= settle_q - 1'b1;
                    if (expired) begin
                        done_q <= 1'b1;
                        etmo_q <= 1'b1;
                    end
                end
                S_READ_STAT: begin
                    if (sample) stat_q <= nand_io_in;
                    if (fin && stat_q[RDY_BIT]) begin
                        done_q <= 1'b1;
                        pass_q <= !stat_q[FAIL_BIT];
                    end else if (fin && expired) begin
                        done_q <= 1'b1;
                        etmo_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        nand_ce_n   = (state_q == S_IDLE) || (state_q == S_WAIT_RB && state_d == S_IDLE);
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_io_out = 8'h00;
        nand_io_oe  = 1'b0;
        req         = 1'b0;
        rd          = 1'b0;
        unique case (state_q)
            S_CMD_LOAD:  begin nand_cle = 1'b1; nand_io_out = OP_LOAD;    nand_io_oe = 1'b1; req = 1'b1; end
            S_CMD_CONF:  begin nand_cle = 1'b1; nand_io_out = OP_CONFIRM; nand_io_oe = 1'b1; req = 1'b1; end
            S_CMD_STAT:  begin nand_cle = 1'b1; nand_io_out = OP_STATUS;  nand_io_oe = 1'b1; req = 1'b1; end
            S_ADDR: begin
                nand_ale   = 1'b1;
                nand_io_oe = 1'b1;
                req        = 1'b1;
                unique case (idx_q[1:0])
                    2'd0: nand_io_out = addr_q[7:0];
                    2'd1: nand_io_out = addr_q[15:8];
                    2'd2: nand_io_out = addr_q[23:16];
                    default: nand_io_out = addr_q[31:24];
                endcase
            end
            S_DATA:      begin nand_io_out = byte_q; nand_io_oe = 1'b1; req = hold_q; end
            S_READ_STAT: begin req = 1'b1; rd = 1'b1; end
            default: ;
        endcase
        din_ready = (state_q == S_DATA) && !hold_q;
        busy      = (state_q != S_IDLE);
        done      = done_q;
        pass      = pass_q;
        err_len   = elen_q;
        err_tmo   = etmo_q;
    end

    // R3: bad length refused on the next clock
    a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && bad_len) |=> (done && err_len && !pass && nand_ce_n));
    // R7: done is a single-clock pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: the sequencer is idle when it reports done
    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: read strobe only with chip enabled and bus released
    a_r9_read_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (!nand_ce_n && !nand_io_oe));
    // R1: latch enables exclusive
    a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R8: timeout never reports pass
    a_r8_tmo_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_tmo) |-> !pass);
endmodule

// File: tb/nand_pgm_ctrl_tb_top.sv
module nand_pgm_ctrl_tb_top;
    localparam int TB_LOW  = 3;
    localparam int TB_HIGH = 2;
    localparam int NV      = 7;
    localparam int V_LEN  [NV] = '{1, 528, 17, 3, 100, 2, 40};
    localparam int V_POLL [NV] = '{0, 0, 1, 1, 0, 1, 1};
    localparam int V_FAIL [NV] = '{0, 0, 0, 1, 1, 0, 1};
    localparam int V_BUSY [NV] = '{30, 60, 200, 5, 120, 1, 90};
    localparam int V_GAP  [NV] = '{0, 0, 1, 0, 1, 1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start = 1'b0;
    logic [31:0] addr = '0;
    logic [9:0]  byte_cnt = '0;
    logic        poll_mode = 1'b0;
    logic [19:0] tmo_lim = 20'd3000;
    logic [7:0]  din;
    logic        din_valid;
    logic        din_ready, busy, done, pass, err_len, err_tmo;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb_n;

    nand_pgm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .byte_cnt(byte_cnt),
        .poll_mode(poll_mode), .tmo_lim(tmo_lim), .din(din), .din_valid(din_valid),
        .din_ready(din_ready), .busy(busy), .done(done), .pass(pass),
        .err_len(err_len), .err_tmo(err_tmo), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n));

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    // configuration seen by the device model
    int cfg_seed = 0, cfg_busy = 10, cfg_gap = 0;
    bit cfg_fail = 0, cfg_poll = 0;
    logic model_clr = 1'b0;

    // payload source
    int tx_cnt = 0;
    int tick = 0;
    assign din       = pat(cfg_seed, tx_cnt);
    assign din_valid = (cfg_gap == 0) ? 1'b1 : tick[1];
    always @(posedge clk) begin
        if (model_clr) tx_cnt <= 0;
        else if (din_ready && din_valid) tx_cnt <= tx_cnt + 1;
    end

    // device model, evaluated at the falling edge
    int busy_left = 0, phase = 0, n_addr = 0, data_cnt = 0, data_err = 0, seq_err = 0;
    int n_80 = 0, n_10 = 0, n_70 = 0, reads = 0, early = 0, r9_bad = 0, quiet_bad = 0;
    int ce_falls = 0, low_run = 0, high_run = 0, low_min = 0, low_max = 0, high_min = 0;
    int last_rdy = 0;
    bit seen_strobe = 0, we_p = 1, re_p = 1, ce_p = 1;
    logic [7:0] addr_got [4];

    assign nand_rb_n  = (busy_left == 0);
    assign nand_io_in = {1'b0, nand_rb_n, 5'b0, cfg_fail};

    always @(negedge clk) begin
        tick <= tick + 1;
        if (model_clr) begin
            busy_left = 0; phase = 0; n_addr = 0; data_cnt = 0; data_err = 0; seq_err = 0;
            n_80 = 0; n_10 = 0; n_70 = 0; reads = 0; early = 0; r9_bad = 0; quiet_bad = 0;
            ce_falls = 0; low_run = 0; high_run = 0; low_min = 999; low_max = 0;
            high_min = 999; seen_strobe = 0; last_rdy = 0;
        end else begin
            if (busy_left > 0) busy_left--;
            if (ce_p && !nand_ce_n) ce_falls++;
            if (nand_ce_n && (!nand_we_n || !nand_re_n)) quiet_bad++;
            if (!nand_re_n && (nand_io_oe || nand_ce_n)) r9_bad++;
            if (!nand_we_n || !nand_re_n) begin
                if ((we_p && re_p) && seen_strobe && high_run < high_min) high_min = high_run;
                low_run++;
                high_run = 0;
            end else begin
                if (!(we_p && re_p)) begin
                    if (low_run < low_min) low_min = low_run;
                    if (low_run > low_max) low_max = low_run;
                    seen_strobe = 1;
                end
                low_run = 0;
                if (!nand_ce_n) high_run++;
            end
            if (!we_p && nand_we_n) begin
                if (nand_cle) begin
                    if (nand_io_out == 8'h80) begin
                        if (phase != 0) seq_err++;
                        phase = 1; n_80++;
                    end else if (nand_io_out == 8'h10) begin
                        if (phase != 2 || data_cnt == 0) seq_err++;
                        phase = 3; n_10++; busy_left = cfg_busy;
                    end else if (nand_io_out == 8'h70) begin
                        if (phase != 3) seq_err++;
                        if (!cfg_poll && busy_left > 0) early++;
                        n_70++;
                    end else seq_err++;
                end else if (nand_ale) begin
                    if (phase != 1 || n_addr > 3) seq_err++;
                    else addr_got[n_addr] = nand_io_out;
                    n_addr++;
                    if (n_addr == 4) phase = 2;
                end else begin
                    if (phase != 2) seq_err++;
                    if (nand_io_out != pat(cfg_seed, data_cnt)) data_err++;
                    data_cnt++;
                end
            end
            if (!re_p && nand_re_n) begin
                reads++;
                last_rdy = nand_rb_n;
            end
        end
        we_p = nand_we_n; re_p = nand_re_n; ce_p = nand_ce_n;
    end

    task automatic clear_model();
        @(negedge clk);
        model_clr = 1'b1;
        @(posedge clk);
        @(posedge clk);
        model_clr = 1'b0;
        @(negedge clk);
    endtask

    int done_cnt = 0;
    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    // issue one request; returns clocks waited for done
    task automatic run_op(input int len, input bit poll, input logic [31:0] a,
                          input int limit, output int waited, output bit busy_after);
        clear_model();
        addr = a; byte_cnt = 10'(len); poll_mode = poll; tmo_lim = 20'(limit);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_after = busy;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    bit ok_finished = 0;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!ok_finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        int waited;
        bit bz;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        // reset state (R10, R3 quiet bus)
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_io_oe, "R4 reset bus idle",
              {nand_ce_n, nand_we_n, nand_re_n, nand_io_oe}, 4'b1110);
        check(!busy && !done && !din_ready, "R10 reset idle", {busy, done, din_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            cfg_seed = v; cfg_busy = V_BUSY[v]; cfg_fail = V_FAIL[v] != 0;
            cfg_poll = V_POLL[v] != 0; cfg_gap = V_GAP[v];
            a = 32'h1234_5600 + 32'(v * 32'h0101_0101);
            run_op(V_LEN[v], V_POLL[v] != 0, a, 3000, waited, bz);
            check(done, "R7 done reached", done, 1);
            check(bz, "R10 busy after start", bz, 1);
            check(!busy, "R10 idle at done", busy, 0);
            check(pass == (V_FAIL[v] == 0), "R7 pass from status bit 0", pass, V_FAIL[v] == 0);
            check(!err_len && !err_tmo, "R8 no error flags", {err_len, err_tmo}, 0);
            check(n_80 == 1 && n_10 == 1 && seq_err == 0, "R1 command order", seq_err, 0);
            check(n_addr == 4 && {addr_got[3], addr_got[2], addr_got[1], addr_got[0]} == a,
                  "R1 address bytes", n_addr, 4);
            check(data_cnt == V_LEN[v] && data_err == 0, "R2 payload count and order",
                  data_cnt, V_LEN[v]);
            check(tx_cnt == V_LEN[v], "R2 stream bytes taken", tx_cnt, V_LEN[v]);
            check(low_min == TB_LOW && low_max == TB_LOW, "R4 strobe low width",
                  low_max, TB_LOW);
            check(high_min >= TB_HIGH, "R4 strobe high width", high_min, TB_HIGH);
            check(r9_bad == 0 && quiet_bad == 0, "R9 read direction", r9_bad, 0);
            check(last_rdy == 1, "R6 last status read ready", last_rdy, 1);
            if (V_POLL[v] == 0) begin
                check(early == 0 && n_70 == 1, "R5 status only after ready", early, 0);
                check(reads == 1, "R5 single status read", reads, 1);
            end else begin
                check(n_70 == 1, "R6 one status command", n_70, 1);
                if (V_BUSY[v] > 100) check(reads > 1, "R6 repeated polling", reads, 2);
            end
            @(negedge clk);
            check(!done, "R7 done single clock", done, 0);
        end

        // R3: illegal byte counts
        for (int k = 0; k < 2; k++) begin
            clear_model();
            byte_cnt = (k == 0) ? 10'd0 : 10'd529;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(done && err_len && !pass, "R3 reject bad length",
                  {done, err_len, pass}, 3'b110);
            repeat (5) @(negedge clk);
            check(ce_falls == 0 && !busy, "R3 bus untouched", ce_falls, 0);
        end

        // R8: device stuck busy, both modes
        for (int m = 0; m < 2; m++) begin
            cfg_busy = 100000; cfg_poll = (m == 1); cfg_gap = 0; cfg_seed = 9; cfg_fail = 0;
            run_op(8, m == 1, 32'hA5A5_0001, 200, waited, bz);
            check(done && err_tmo && !pass, "R8 timeout flagged", {done, err_tmo, pass}, 3'b110);
            @(negedge clk);
            check(nand_ce_n && !busy, "R8 chip enable released", nand_ce_n, 1);
            if (m == 0) check(n_70 == 0, "R5 no status while busy", n_70, 0);
            else        check(reads > 1, "R6 polled until timeout", reads, 2);
        end

        // R10: start while busy is ignored
        cfg_busy = 20; cfg_poll = 0; cfg_seed = 3; cfg_fail = 0; cfg_gap = 0;
        clear_model();
        addr = 32'h0000_0042; byte_cnt = 10'd6; poll_mode = 1'b0; tmo_lim = 20'd3000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        byte_cnt = 10'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && busy, "R10 start ignored while busy", done, 0);
        waited = 0;
        while (!done && waited < 20000) begin @(negedge clk); waited++; end
        check(done && pass && !err_len, "R10 original operation completes", pass, 1);
        check(data_cnt == 6 && n_80 == 1, "R10 single sequence", n_80, 1);

        ok_finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule